// File: doc/BRIEF.md
# Tachometer Timer Register and Interrupt Front End

This block is the bus-facing register file of a fan tachometer timer. It decodes a small halfword-aligned address map and checks every access against the width that the target register allows. It holds the timer's control fields and drives them out to the timer core. Six event strobes from the core (capture, underflow and compare, for each of the two channels) set bits in a pending register. Software clears those bits by writing ones to a separate write-only clear register. A per-bit enable mask gates them onto a single level-sensitive interrupt line.

The block also makes the prescaled tick enable from the prescale field, with a period of the prescale value plus one clock cycles. Reset is selective: the count and capture registers keep their contents, and all control, pending and enable state returns to zero. An access that is rejected raises an error flag for one cycle, changes nothing, and reads as zero.

Top module: `tach_regif`

## Requirements
- R1: The halfword registers are at offsets 0x00 (count A), 0x02 (capture A), 0x04 (capture B), 0x06 (count B), 0x14 (compare reference A) and 0x16 (compare reference B). They accept only halfword accesses (`busHalf`=1). Every other mapped register accepts only byte accesses (`busHalf`=0). A wrong-width access raises `accErr` for one cycle, updates no register, and returns `rdData`=0.
- R2: An odd offset, or any offset above 0x1C, is rejected with `accErr`, no update and zero read data.
- R3: A read of the clear register (offset 0x10) is rejected with `accErr` and returns zero. An access that asserts `busRd` and `busWr` together is also rejected.
- R4: The pending register is at offset 0x0E. Bit 0 is capture A, bit 1 is capture B, bit 2 is underflow A, bit 3 is underflow B, bit 4 is compare A and bit 5 is compare B; bits 7:6 read zero. `evtStrobe[i]` sets pending bit i one cycle later, whatever the enable mask holds.
- R5: A byte write to offset 0x10 clears each pending bit whose written bit is 1 and leaves every other pending bit as it was.
- R6: When an event and a clear reach the same pending bit in the same cycle, the bit ends up set.
- R7: The enable mask at offset 0x12 uses the pending layout. `irq` is high exactly when some pending bit has its enable bit set.
- R8: A byte write to the pending register is accepted without `accErr` and leaves the pending bits unchanged.
- R9: `tickEn` is high once every (prescale+1) cycles, where prescale is the byte at offset 0x08. With prescale 0 it is high on every cycle.
- R10: Reset clears the registers at offsets 0x08 through 0x1C and drives `irq` low. It leaves the count and capture registers (0x00 to 0x06) holding their values.
- R11: An accepted read returns its data on `rdData` in the cycle after the strobe; in every other cycle `rdData` is zero. Byte registers read back zero-extended. The input selector registers (0x1A, 0x1C) keep only bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Byte offset of the access |
| busHalf | input | 1 | 1 = halfword access, 0 = byte access |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWdata | input | 16 | Write data; byte writes use bits 7:0 |
| evtStrobe | input | 6 | Event strobes from the timer core, in the pending layout |
| rdData | output | 16 | Read data, one cycle after the read strobe |
| accErr | output | 1 | One-cycle pulse for a rejected access |
| irq | output | 1 | Level interrupt |
| tickEn | output | 1 | Prescaled tick enable |
| prescale | output | 8 | Prescale field |
| clkCfg | output | 8 | Counter clock selection field |
| modeCfg | output | 8 | Mode and channel enable field |
| cmpRefA | output | 16 | Compare reference, channel A |
| cmpRefB | output | 16 | Compare reference, channel B |
| cmpCfg | output | 8 | Compare condition field, both channels |
| inSelA | output | 1 | Input selector, channel A |
| inSelB | output | 1 | Input selector, channel B |

## Verification
A bus strobe is held for one cycle. Its read data and error flag are registered, so they appear after the next rising edge. The bench samples them at the falling edge that follows, one cycle after the strobe. An event strobe or a clear write changes the pending register at the next edge, and `irq` follows at once from the registered state, so the bench reads both at the next falling edge. `tickEn` is measured by counting falling edges between two high samples, which checks the period without relying on the phase of the tick counter.

// File: rtl/tach_regif_pkg.sv
package tach_regif_pkg;
  localparam int HALF_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 5;
  localparam int EVT_N   = 6;
  localparam int IDX_W   = ADDR_W - 1;
  localparam int LAST_IDX = 14;

  typedef enum logic [IDX_W-1:0] {
    REG_CNTA     = 4'd0,
    REG_CAPA     = 4'd1,
    REG_CAPB     = 4'd2,
    REG_CNTB     = 4'd3,
    REG_PRESCALE = 4'd4,
    REG_CLKCFG   = 4'd5,
    REG_MODE     = 4'd6,
    REG_PEND     = 4'd7,
    REG_PCLR     = 4'd8,
    REG_IEN      = 4'd9,
    REG_CMPA     = 4'd10,
    REG_CMPB     = 4'd11,
    REG_CMPCFG   = 4'd12,
    REG_SELA     = 4'd13,
    REG_SELB     = 4'd14
  } regSel_e;

  // Strobes passed from the decoder to the register datapath
  typedef struct packed {
    logic    wr;
    logic    rd;
    logic    err;
    regSel_e sel;
  } busStb_t;

  function automatic logic isHalfReg(regSel_e s);
    case (s)
      REG_CNTA, REG_CAPA, REG_CAPB, REG_CNTB, REG_CMPA, REG_CMPB: isHalfReg = 1'b1;
      default: isHalfReg = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/tach_regif_ctrl.sv
module tach_regif_ctrl
  import tach_regif_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busHalf,
  input  logic              busRd,
  input  logic              busWr,
  output busStb_t           stb
);
  logic [IDX_W-1:0] idx;
  logic             inMap;
  logic             widthOk;
  logic             clrRead;
  logic             bothStb;
  logic             reject;
  regSel_e          sel;

  always_comb begin
    idx     = busAddr[ADDR_W-1:1];
    inMap   = !busAddr[0] && (idx <= IDX_W'(LAST_IDX));
    sel     = inMap ? regSel_e'(idx) : REG_CNTA;
    widthOk = (isHalfReg(sel) == busHalf);
    clrRead = busRd && (sel == REG_PCLR);
    bothStb = busRd && busWr;
    reject  = (busRd || busWr) && (!inMap || !widthOk || clrRead || bothStb);

    stb.sel = sel;
    stb.err = reject;
    stb.wr  = busWr && !reject;
    stb.rd  = busRd && !reject;
  end
endmodule

// File: rtl/tach_regif_dp.sv
module tach_regif_dp
  import tach_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  busStb_t           stb,
  input  logic [HALF_W-1:0] busWdata,
  input  logic [EVT_N-1:0]  evtStrobe,
  output logic [HALF_W-1:0] rdData,
  output logic              accErr,
  output logic              irq,
  output logic              tickEn,
  output logic [EVT_N-1:0]  pendOut,
  output logic [BYTE_W-1:0] prescale,
  output logic [BYTE_W-1:0] clkCfg,
  output logic [BYTE_W-1:0] modeCfg,
  output logic [HALF_W-1:0] cmpRefA,
  output logic [HALF_W-1:0] cmpRefB,
  output logic [BYTE_W-1:0] cmpCfg,
  output logic              inSelA,
  output logic              inSelB
);
  localparam int PAD_PEND = BYTE_W - EVT_N;

  // Count and capture registers: kept across reset
  logic [HALF_W-1:0] cntAQ, capAQ, capBQ, cntBQ;

  // Control state: cleared by reset
  logic [BYTE_W-1:0] prsQ, ckcQ, modeQ, ccfgQ;
  logic [HALF_W-1:0] cmpAQ, cmpBQ;
  logic [EVT_N-1:0]  pendQ, ienQ;
  logic              selAQ, selBQ;

  logic [BYTE_W-1:0] tickCntQ;
  logic [HALF_W-1:0] rdQ;
  logic              errQ;

  logic [EVT_N-1:0]  clrMask;
  logic [HALF_W-1:0] rdMux;
  logic              tickHit;

  // Registers that reset leaves alone
  always_ff @(posedge clk) begin
    if (stb.wr) begin
      case (stb.sel)
        REG_CNTA: cntAQ <= busWdata;
        REG_CAPA: capAQ <= busWdata;
        REG_CAPB: capBQ <= busWdata;
        REG_CNTB: cntBQ <= busWdata;
        default: ;
      endcase
    end
  end

  // Control registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prsQ  <= '0;
      ckcQ  <= '0;
      modeQ <= '0;
      ccfgQ <= '0;
      cmpAQ <= '0;
      cmpBQ <= '0;
      ienQ  <= '0;
      selAQ <= 1'b0;
      selBQ <= 1'b0;
    end else if (stb.wr) begin
      case (stb.sel)
        REG_PRESCALE: prsQ  <= busWdata[BYTE_W-1:0];
        REG_CLKCFG:   ckcQ  <= busWdata[BYTE_W-1:0];
        REG_MODE:     modeQ <= busWdata[BYTE_W-1:0];
        REG_CMPCFG:   ccfgQ <= busWdata[BYTE_W-1:0];
        REG_CMPA:     cmpAQ <= busWdata;
        REG_CMPB:     cmpBQ <= busWdata;
        REG_IEN:      ienQ  <= busWdata[EVT_N-1:0];
        REG_SELA:     selAQ <= busWdata[0];
        REG_SELB:     selBQ <= busWdata[0];
        default: ;
      endcase
    end
  end

  // Pending bits: clear first, then events set, so an event wins
  always_comb begin
    clrMask = (stb.wr && stb.sel == REG_PCLR) ? busWdata[EVT_N-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= (pendQ & ~clrMask) | evtStrobe;
  end

  // Prescaled tick: period prsQ + 1 cycles
  always_comb tickHit = (tickCntQ >= prsQ);

  always_ff @(posedge clk) begin
    if (!rstN)        tickCntQ <= '0;
    else if (tickHit) tickCntQ <= '0;
    else              tickCntQ <= tickCntQ + 1'b1;
  end

  // Read path
  always_comb begin
    rdMux = '0;
    case (stb.sel)
      REG_CNTA:     rdMux = cntAQ;
      REG_CAPA:     rdMux = capAQ;
      REG_CAPB:     rdMux = capBQ;
      REG_CNTB:     rdMux = cntBQ;
      REG_PRESCALE: rdMux = HALF_W'(prsQ);
      REG_CLKCFG:   rdMux = HALF_W'(ckcQ);
      REG_MODE:     rdMux = HALF_W'(modeQ);
      REG_PEND:     rdMux = HALF_W'({{PAD_PEND{1'b0}}, pendQ});
      REG_IEN:      rdMux = HALF_W'({{PAD_PEND{1'b0}}, ienQ});
      REG_CMPA:     rdMux = cmpAQ;
      REG_CMPB:     rdMux = cmpBQ;
      REG_CMPCFG:   rdMux = HALF_W'(ccfgQ);
      REG_SELA:     rdMux = HALF_W'(selAQ);
      REG_SELB:     rdMux = HALF_W'(selBQ);
      default:      rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQ  <= '0;
      errQ <= 1'b0;
    end else begin
      rdQ  <= stb.rd ? rdMux : '0;
      errQ <= stb.err;
    end
  end

  assign rdData   = rdQ;
  assign accErr   = errQ;
  assign irq      = |(pendQ & ienQ);
  assign tickEn   = tickHit;
  assign pendOut  = pendQ;
  assign prescale = prsQ;
  assign clkCfg   = ckcQ;
  assign modeCfg  = modeQ;
  assign cmpRefA  = cmpAQ;
  assign cmpRefB  = cmpBQ;
  assign cmpCfg   = ccfgQ;
  assign inSelA   = selAQ;
  assign inSelB   = selBQ;
endmodule

// File: rtl/tach_regif.sv
module tach_regif
  import tach_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busHalf,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [HALF_W-1:0] busWdata,
  input  logic [EVT_N-1:0]  evtStrobe,
  output logic [HALF_W-1:0] rdData,
  output logic              accErr,
  output logic              irq,
  output logic              tickEn,
  output logic [BYTE_W-1:0] prescale,
  output logic [BYTE_W-1:0] clkCfg,
  output logic [BYTE_W-1:0] modeCfg,
  output logic [HALF_W-1:0] cmpRefA,
  output logic [HALF_W-1:0] cmpRefB,
  output logic [BYTE_W-1:0] cmpCfg,
  output logic              inSelA,
  output logic              inSelB
);
  busStb_t          stb;
  logic [EVT_N-1:0] pendView;

  tach_regif_ctrl u_ctrl (
    .busAddr (busAddr),
    .busHalf (busHalf),
    .busRd   (busRd),
    .busWr   (busWr),
    .stb     (stb)
  );

  tach_regif_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busWdata  (busWdata),
    .evtStrobe (evtStrobe),
    .rdData    (rdData),
    .accErr    (accErr),
    .irq       (irq),
    .tickEn    (tickEn),
    .pendOut   (pendView),
    .prescale  (prescale),
    .clkCfg    (clkCfg),
    .modeCfg   (modeCfg),
    .cmpRefA   (cmpRefA),
    .cmpRefB   (cmpRefB),
    .cmpCfg    (cmpCfg),
    .inSelA    (inSelA),
    .inSelB    (inSelB)
  );
endmodule

// File: rtl/tach_regif_chk.sv
module tach_regif_chk
  import tach_regif_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRd,
  input logic              busWr,
  input logic [HALF_W-1:0] rdData,
  input logic              accErr,
  input logic [EVT_N-1:0]  evtStrobe,
  input logic [EVT_N-1:0]  pendQ,
  input logic              irq,
  input logic [BYTE_W-1:0] prescale,
  input logic              tickEn
);
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> (rdData == '0)); // R1

  AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> $past(busRd || busWr)); // R2

  AST_CLR_READ_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !busWr && busAddr == 5'h10) |=> (accErr && rdData == '0)); // R3

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (|evtStrobe) |=> ((pendQ & $past(evtStrobe)) == $past(evtStrobe))); // R6

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ == '0) |-> !irq); // R7

  AST_TICK_EVERY: assert property (@(posedge clk) disable iff (!rstN)
    (prescale == '0) |-> tickEn); // R9
endmodule

bind tach_regif tach_regif_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busRd     (busRd),
  .busWr     (busWr),
  .rdData    (rdData),
  .accErr    (accErr),
  .evtStrobe (evtStrobe),
  .pendQ     (pendView),
  .irq       (irq),
  .prescale  (prescale),
  .tickEn    (tickEn)
);

// File: tb/tach_regif_bench.sv
`timescale 1ns/1ps
module tach_regif_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busHalf = 1'b0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [15:0] busWdata = '0;
  logic [5:0]  evtStrobe = '0;
  logic [15:0] rdData;
  logic        accErr, irq, tickEn;
  logic [7:0]  prescale, clkCfg, modeCfg, cmpCfg;
  logic [15:0] cmpRefA, cmpRefB;
  logic        inSelA, inSelB;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  tach_regif u_tach_regif (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busHalf(busHalf),
    .busRd(busRd), .busWr(busWr), .busWdata(busWdata), .evtStrobe(evtStrobe),
    .rdData(rdData), .accErr(accErr), .irq(irq), .tickEn(tickEn),
    .prescale(prescale), .clkCfg(clkCfg), .modeCfg(modeCfg),
    .cmpRefA(cmpRefA), .cmpRefB(cmpRefB), .cmpCfg(cmpCfg),
    .inSelA(inSelA), .inSelB(inSelB)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One bus cycle, driven at a falling edge; results sampled one cycle later
  task automatic busOp(input logic wr, input logic rd, input logic half,
                       input logic [4:0] addr, input logic [15:0] wd,
                       input logic [5:0] evt,
                       output logic [15:0] rdv, output logic errv);
    @(negedge clk);
    busWr = wr; busRd = rd; busHalf = half; busAddr = addr; busWdata = wd;
    evtStrobe = evt;
    @(negedge clk);
    busWr = 1'b0; busRd = 1'b0; evtStrobe = '0;
    rdv = rdData; errv = accErr;
  endtask

  task automatic wr8(input logic [4:0] a, input logic [7:0] d);
    logic [15:0] r; logic e;
    busOp(1'b1, 1'b0, 1'b0, a, {8'h00, d}, 6'h0, r, e);
  endtask

  task automatic wr16(input logic [4:0] a, input logic [15:0] d);
    logic [15:0] r; logic e;
    busOp(1'b1, 1'b0, 1'b1, a, d, 6'h0, r, e);
  endtask

  task automatic rdChk(input string req, input logic half, input logic [4:0] a,
                       input logic [15:0] expD, input logic expE);
    logic [15:0] r; logic e;
    busOp(1'b0, 1'b1, half, a, 16'h0, 6'h0, r, e);
    check(req, r, expD);
    check(req, {15'h0, e}, {15'h0, expE});
  endtask

  task automatic pulseEvt(input logic [5:0] evt);
    @(negedge clk);
    evtStrobe = evt;
    @(negedge clk);
    evtStrobe = '0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testResetState();
    check("R10 prescale after reset", {8'h0, prescale}, 16'h0);
    check("R10 irq after reset", {15'h0, irq}, 16'h0);
    rdChk("R10 pending after reset", 1'b0, 5'h0E, 16'h0000, 1'b0);
    rdChk("R11 idle rdData", 1'b0, 5'h12, 16'h0000, 1'b0);
    check("R11 rdData zero without read", rdData, 16'h0);
  endtask

  task automatic testWidths();
    logic [15:0] r; logic e;
    wr16(5'h14, 16'hBEEF);
    rdChk("R1 halfword readback", 1'b1, 5'h14, 16'hBEEF, 1'b0);
    busOp(1'b1, 1'b0, 1'b0, 5'h14, 16'h0011, 6'h0, r, e);
    check("R1 byte write to halfword reg errs", {15'h0, e}, 16'h1);
    rdChk("R1 halfword reg unchanged", 1'b1, 5'h14, 16'hBEEF, 1'b0);
    rdChk("R1 byte read of count reg", 1'b0, 5'h00, 16'h0000, 1'b1);
    busOp(1'b1, 1'b0, 1'b1, 5'h08, 16'h0009, 6'h0, r, e);
    check("R1 halfword write to byte reg errs", {15'h0, e}, 16'h1);
    check("R1 prescale unchanged", {8'h0, prescale}, 16'h0);
  endtask

  task automatic testUnmapped();
    logic [15:0] r; logic e;
    rdChk("R2 offset 0x1E", 1'b1, 5'h1E, 16'h0, 1'b1);
    rdChk("R2 odd offset", 1'b0, 5'h09, 16'h0, 1'b1);
    busOp(1'b1, 1'b0, 1'b0, 5'h1F, 16'h00FF, 6'h0, r, e);
    check("R2 write above map errs", {15'h0, e}, 16'h1);
  endtask

  task automatic testClrRead();
    logic [15:0] r; logic e;
    wr8(5'h12, 8'h3F);
    rdChk("R3 clear register read", 1'b0, 5'h10, 16'h0, 1'b1);
    busOp(1'b1, 1'b1, 1'b0, 5'h12, 16'h0000, 6'h0, r, e);
    check("R3 read and write together errs", {15'h0, e}, 16'h1);
    rdChk("R3 enable unchanged", 1'b0, 5'h12, 16'h003F, 1'b0);
    wr8(5'h12, 8'h00);
  endtask

  task automatic testPendIrq();
    pulseEvt(6'h04);
    check("R4 event sets pending with enable off", {15'h0, irq}, 16'h0);
    rdChk("R4 underflow A is bit 2", 1'b0, 5'h0E, 16'h0004, 1'b0);
    wr8(5'h12, 8'h04);
    check("R7 irq when enabled bit pending", {15'h0, irq}, 16'h1);
    wr8(5'h12, 8'h02);
    check("R7 irq low when enable misses", {15'h0, irq}, 16'h0);
    wr8(5'h10, 8'h3F);
  endtask

  task automatic testClear();
    pulseEvt(6'h3F);
    rdChk("R4 all six bits set", 1'b0, 5'h0E, 16'h003F, 1'b0);
    wr8(5'h10, 8'h05);
    rdChk("R5 selective clear", 1'b0, 5'h0E, 16'h003A, 1'b0);
    wr8(5'h0E, 8'h00);
    rdChk("R8 pending write ignored", 1'b0, 5'h0E, 16'h003A, 1'b0);
    wr8(5'h10, 8'hFF);
    rdChk("R5 clear all", 1'b0, 5'h0E, 16'h0000, 1'b0);
  endtask

  task automatic testRace();
    logic [15:0] r; logic e;
    pulseEvt(6'h01);
    busOp(1'b1, 1'b0, 1'b0, 5'h10, 16'h0003, 6'h02, r, e);
    rdChk("R6 event beats same-cycle clear", 1'b0, 5'h0E, 16'h0002, 1'b0);
    wr8(5'h10, 8'h3F);
  endtask

  task automatic testTick();
    int gap;
    wr8(5'h08, 8'h03);
    @(negedge clk);
    while (!tickEn) @(negedge clk);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!tickEn && gap < 50);
    check("R9 tick period prescale 3", 16'(gap), 16'd4);
    wr8(5'h08, 8'h00);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R9 tick every cycle at prescale 0", {15'h0, tickEn}, 16'h1);
    end
  endtask

  task automatic testReadback();
    wr8(5'h18, 8'hFF);
    rdChk("R11 byte reg zero-extended", 1'b0, 5'h18, 16'h00FF, 1'b0);
    wr8(5'h1A, 8'hFF);
    rdChk("R11 selector keeps bit 0", 1'b0, 5'h1A, 16'h0001, 1'b0);
    check("R11 selector output", {15'h0, inSelA}, 16'h1);
  endtask

  task automatic testSelectiveReset();
    wr16(5'h00, 16'h1234);
    wr16(5'h04, 16'h5678);
    wr16(5'h16, 16'h9ABC);
    wr8(5'h08, 8'h07);
    wr8(5'h1C, 8'h01);
    wr8(5'h12, 8'h01);
    pulseEvt(6'h01);
    check("R7 irq before reset", {15'h0, irq}, 16'h1);
    doReset();
    check("R10 irq low after reset", {15'h0, irq}, 16'h0);
    rdChk("R10 count A kept", 1'b1, 5'h00, 16'h1234, 1'b0);
    rdChk("R10 capture B kept", 1'b1, 5'h04, 16'h5678, 1'b0);
    rdChk("R10 prescale cleared", 1'b0, 5'h08, 16'h0000, 1'b0);
    rdChk("R10 compare B cleared", 1'b1, 5'h16, 16'h0000, 1'b0);
    rdChk("R10 selector B cleared", 1'b0, 5'h1C, 16'h0000, 1'b0);
    rdChk("R10 enable cleared", 1'b0, 5'h12, 16'h0000, 1'b0);
    rdChk("R10 pending cleared", 1'b0, 5'h0E, 16'h0000, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testResetState();
    testWidths();
    testUnmapped();
    testClrRead();
    testPendIrq();
    testClear();
    testRace();
    testTick();
    testReadback();
    testSelectiveReset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule